// File: doc/BRIEF.md
# Go-Back-N Link Transmitter

This block is the sending end of a point-to-point flit link that uses positive and negative acknowledgements. Flits enter through a valid/ready handshake and leave on a flit bus qualified by a request strobe. They go out at once, without waiting for permission from the far end. Each transmitted flit is kept in a circular retransmission store until the receiver confirms it. The repeaters between the two ends are plain registers. As a result every response returns a fixed number of cycles after its flit was launched, and it returns in launch order.

A positive response frees the oldest held flit. A negative response makes the sender go back to that oldest flit and send it and everything after it again. Responses already in the return path for flits sent before the rewind took effect are then ignored, because those flits are about to be repeated. Flits offered upstream while a rewind is in progress are still accepted into free slots, and they follow the replayed ones in order.

Top module: `gbn_link_tx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `tx_req` is low and `in_ready` is high (the store is empty).
- R2: Every accepted flit is driven on `tx_flit` with `tx_req` high, in acceptance order, without waiting for any response. `tx_req` is high whenever a held flit has not been sent since the last rewind.
- R3: `in_ready` is high exactly when fewer than `DEPTH` flits are held. A flit stays held until a counted positive response for it arrives.
- R4: A response is signalled by `rsp_valid` high, with `rsp_ack` = 1 for a positive response and 0 for a negative one. Each counted response refers to the oldest held flit.
- R5: In the cycle after a counted negative response, `tx_flit` carries the oldest held flit with `tx_req` high. The flits after it then follow again in order.
- R6: After a counted negative response, the next N responses are ignored whatever their value. N is the number of transmissions still awaiting a response, including any transmission made in the cycle of the negative response.
- R7: A counted positive response releases exactly one held flit. Once every accepted flit has been acknowledged, `tx_req` is low and `in_ready` is high.
- R8: `DEPTH` must be at least 2*`LINK_STAGES`+2, and this is checked at elaboration. With that depth and no negative responses, a continuous stream never sees `in_ready` low. Transmissions awaiting a response never exceed 2*`LINK_STAGES`.
- R9: Under random negative responses, a receiver that accepts only the expected next flit receives every accepted flit exactly once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Upstream flit offered |
| in_ready | output | 1 | A free slot exists; the flit is taken when both are high |
| in_flit | input | FLIT_W | Upstream flit data |
| tx_req | output | 1 | Link request strobe; `tx_flit` is valid |
| tx_flit | output | FLIT_W | Link flit data |
| rsp_valid | input | 1 | A response from the return path is present |
| rsp_ack | input | 1 | 1 = positive, 0 = negative (meaningful with `rsp_valid`) |

## Verification
The assertions assume that the far end answers every transmission exactly once, 2*`LINK_STAGES` cycles after it left, and never answers when nothing is outstanding. The bench meets this by building the forward and return paths from `LINK_STAGES` register stages each, around a receiver that responds to every flit it sees. The receiver drops the flits that arrive during the replay window and answers them with random values. In that way the bench checks that the sender really discards those stale responses rather than counting them.

// File: rtl/gbn_link_pkg.sv
`timescale 1ns/1ps
package gbn_link_pkg;

   typedef enum logic [1:0] {
      RSP_IDLE = 2'd0,
      RSP_POS  = 2'd1,
      RSP_NEG  = 2'd2
   } rsp_kind_e;

   function automatic rsp_kind_e classify_rsp(input logic vld, input logic ack);
      if (!vld)     return RSP_IDLE;
      else if (ack) return RSP_POS;
      else          return RSP_NEG;
   endfunction

endpackage

// File: rtl/gbn_retx_buf.sv
`timescale 1ns/1ps
module gbn_retx_buf #(
   parameter int FLIT_W      = 32,
   parameter int DEPTH       = 6,
   parameter int IDX_W       = 3,
   parameter bit ONEHOT_READ = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [FLIT_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [FLIT_W-1:0] rd_data
);

   logic [FLIT_W-1:0] slot [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic              hit;
      logic [FLIT_W-1:0] slot_q;

      assign hit = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   slot_q <= '0;
         else if (hit) slot_q <= wr_data;
      end

      assign slot[g] = slot_q;
   end

   if (ONEHOT_READ) begin : g_rd_andor
      logic [DEPTH-1:0] sel;
      always_comb begin
         for (int i = 0; i < DEPTH; i++) sel[i] = (rd_idx == IDX_W'(i));
         rd_data = '0;
         for (int i = 0; i < DEPTH; i++) rd_data |= slot[i] & {FLIT_W{sel[i]}};
      end
   end else begin : g_rd_index
      assign rd_data = slot[rd_idx];
   end

endmodule

// File: rtl/gbn_rsp_filter.sv
`timescale 1ns/1ps
module gbn_rsp_filter #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_fire,
   input  logic             rsp_valid,
   input  logic             rsp_ack,
   output logic             ack_live,
   output logic             nack_live,
   output logic [CNT_W-1:0] infl_cnt
);
   import gbn_link_pkg::*;

   rsp_kind_e        kind;
   logic             dropping;
   logic [CNT_W-1:0] infl_nxt;
   logic [CNT_W-1:0] drop_cnt;

   always_comb begin
      kind      = classify_rsp(rsp_valid, rsp_ack);
      dropping  = (drop_cnt != '0);
      ack_live  = (kind == RSP_POS) && !dropping;
      nack_live = (kind == RSP_NEG) && !dropping;
      infl_nxt  = infl_cnt + CNT_W'(tx_fire) - CNT_W'(rsp_valid);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         infl_cnt <= '0;
         drop_cnt <= '0;
      end else begin
         infl_cnt <= infl_nxt;
         if (nack_live)                  drop_cnt <= infl_nxt;
         else if (rsp_valid && dropping) drop_cnt <= drop_cnt - 1'b1;
      end
   end

   // R6
   drop_within_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop_cnt <= infl_cnt);

   // R4
   rsp_has_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (infl_cnt != '0));

   // R6
   stale_rsp_no_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && dropping) |=> (drop_cnt == $past(drop_cnt) - 1'b1));

endmodule

// File: rtl/gbn_seq_ctrl.sv
`timescale 1ns/1ps
module gbn_seq_ctrl #(
   parameter int DEPTH = 6,
   parameter int IDX_W = 3,
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_fire,
   input  logic             tx_fire,
   input  logic             ack_live,
   input  logic             nack_live,
   output logic [IDX_W-1:0] send_idx,
   output logic [IDX_W-1:0] tail_idx,
   output logic [CNT_W-1:0] occ_cnt,
   output logic [CNT_W-1:0] pend_cnt
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] CAP      = CNT_W'(DEPTH);

   logic [IDX_W-1:0] head_idx;
   logic [CNT_W-1:0] occ_nxt;

   function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i);
      return (i == LAST_IDX) ? '0 : i + 1'b1;
   endfunction

   assign occ_nxt = occ_cnt + CNT_W'(wr_fire) - CNT_W'(ack_live);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_idx <= '0;
         send_idx <= '0;
         tail_idx <= '0;
         occ_cnt  <= '0;
         pend_cnt <= '0;
      end else begin
         occ_cnt <= occ_nxt;
         if (ack_live) head_idx <= step(head_idx);
         if (wr_fire)  tail_idx <= step(tail_idx);
         if (nack_live) begin
            send_idx <= head_idx;
            pend_cnt <= occ_nxt;
         end else begin
            if (tx_fire) send_idx <= step(send_idx);
            pend_cnt <= pend_cnt + CNT_W'(wr_fire) - CNT_W'(tx_fire);
         end
      end
   end

   // R3
   occ_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ_cnt <= CAP);

   // R2
   pend_within_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_cnt <= occ_cnt);

   // R5
   rewind_to_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nack_live |=> (send_idx == $past(head_idx)));

   // R7
   head_moves_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_live |=> $stable(head_idx));

endmodule

// File: rtl/gbn_link_tx.sv
`timescale 1ns/1ps
module gbn_link_tx #(
   parameter int FLIT_W      = 32,
   parameter int LINK_STAGES = 2,
   parameter int DEPTH       = 6,
   parameter bit ONEHOT_READ = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [FLIT_W-1:0] in_flit,
   output logic              tx_req,
   output logic [FLIT_W-1:0] tx_flit,
   input  logic              rsp_valid,
   input  logic              rsp_ack
);

   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int RTT   = 2 * LINK_STAGES;
   localparam logic [CNT_W-1:0] CAP   = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] RTT_C = CNT_W'(RTT);

   // R8: a full round trip plus the write cycle must fit in the store
   if (LINK_STAGES < 1) begin : g_bad_stages
      $error("gbn_link_tx: LINK_STAGES must be at least 1");
   end
   if (DEPTH < 2 * LINK_STAGES + 2) begin : g_bad_depth
      $error("gbn_link_tx: DEPTH must be at least 2*LINK_STAGES+2");
   end
   if (FLIT_W < 1) begin : g_bad_width
      $error("gbn_link_tx: FLIT_W must be positive");
   end

   logic             wr_fire;
   logic             tx_fire;
   logic             ack_live;
   logic             nack_live;
   logic [IDX_W-1:0] send_idx;
   logic [IDX_W-1:0] tail_idx;
   logic [CNT_W-1:0] occ_cnt;
   logic [CNT_W-1:0] pend_cnt;
   logic [CNT_W-1:0] infl_cnt;

   assign in_ready = (occ_cnt < CAP);
   assign wr_fire  = in_valid && in_ready;
   assign tx_req   = (pend_cnt != '0);
   assign tx_fire  = tx_req;

   gbn_retx_buf #(
      .FLIT_W      (FLIT_W),
      .DEPTH       (DEPTH),
      .IDX_W       (IDX_W),
      .ONEHOT_READ (ONEHOT_READ)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_fire),
      .wr_idx  (tail_idx),
      .wr_data (in_flit),
      .rd_idx  (send_idx),
      .rd_data (tx_flit)
   );

   gbn_seq_ctrl #(
      .DEPTH (DEPTH),
      .IDX_W (IDX_W),
      .CNT_W (CNT_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_fire   (wr_fire),
      .tx_fire   (tx_fire),
      .ack_live  (ack_live),
      .nack_live (nack_live),
      .send_idx  (send_idx),
      .tail_idx  (tail_idx),
      .occ_cnt   (occ_cnt),
      .pend_cnt  (pend_cnt)
   );

   gbn_rsp_filter #(
      .CNT_W (CNT_W)
   ) u_rsp (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_fire   (tx_fire),
      .rsp_valid (rsp_valid),
      .rsp_ack   (rsp_ack),
      .ack_live  (ack_live),
      .nack_live (nack_live),
      .infl_cnt  (infl_cnt)
   );

   // R8
   round_trip_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      infl_cnt <= RTT_C);

   // R5
   replay_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      nack_live |=> tx_req);

endmodule

// File: tb/gbn_link_tx_test.sv
`timescale 1ns/1ps
module gbn_link_tx_test;

   localparam int W = 16;
   localparam int S = 3;
   localparam int D = 2 * S + 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [W-1:0] in_flit = '0;
   logic         tx_req;
   logic [W-1:0] tx_flit;
   logic         rsp_valid;
   logic         rsp_ack;

   always #2 clk = ~clk;

   gbn_link_tx #(.FLIT_W(W), .LINK_STAGES(S), .DEPTH(D), .ONEHOT_READ(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
      .tx_req(tx_req), .tx_flit(tx_flit), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack)
   );

   // register-only link model: S stages out, S stages back
   logic         fwd_v [S];
   logic [W-1:0] fwd_d [S];
   logic         ret_v [S];
   logic         ret_a [S];
   logic         ret_r [S];
   assign rsp_valid = ret_v[S-1];
   assign rsp_ack   = ret_a[S-1];

   int n_chk = 0, n_bad = 0;
   int nack_pct = 0, phase = 0;
   int accepted = 0, acked = 0, delivered = 0, nack_events = 0, full_seen = 0;
   int skip = 0;
   logic [W-1:0] exp_q [$];
   logic [W-1:0] held_q [$];

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   // link, receiver and response bookkeeping
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < S; i++) begin
            fwd_v[i] <= 1'b0; fwd_d[i] <= '0;
            ret_v[i] <= 1'b0; ret_a[i] <= 1'b0; ret_r[i] <= 1'b0;
         end
         skip = 0;
      end else begin
         fwd_v[0] <= tx_req;
         fwd_d[0] <= tx_flit;
         for (int i = 1; i < S; i++) begin
            fwd_v[i] <= fwd_v[i-1]; fwd_d[i] <= fwd_d[i-1];
            ret_v[i] <= ret_v[i-1]; ret_a[i] <= ret_a[i-1]; ret_r[i] <= ret_r[i-1];
         end
         ret_v[0] <= 1'b0; ret_a[0] <= 1'b0; ret_r[0] <= 1'b0;
         if (skip > 0) begin
            skip--;
            // R6: stale flits get random answers that the sender must ignore
            if (fwd_v[S-1]) begin
               ret_v[0] <= 1'b1;
               ret_a[0] <= 1'($urandom_range(0, 1));
            end
         end else if (fwd_v[S-1]) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R9 flit with nothing outstanding", longint'(fwd_d[S-1]), 0);
            end else if (int'($urandom_range(0, 99)) < nack_pct) begin
               ret_v[0] <= 1'b1; ret_r[0] <= 1'b1; skip = 2 * S;
            end else begin
               check(fwd_d[S-1] == exp_q[0], "R2 R9 delivered flit order",
                     longint'(fwd_d[S-1]), longint'(exp_q[0]));
               ret_v[0] <= 1'b1; ret_r[0] <= 1'b1;
               if (fwd_d[S-1] == exp_q[0]) begin
                  ret_a[0] <= 1'b1;
                  void'(exp_q.pop_front());
                  delivered++;
               end else begin
                  skip = 2 * S;
               end
            end
         end
         if (ret_v[S-1] && ret_r[S-1]) begin
            if (ret_a[S-1]) begin
               acked++;
               if (held_q.size() > 0) void'(held_q.pop_front());
            end else begin
               nack_events++;
            end
         end
      end
   end

   // monitor: compares port values against the model once per cycle
   initial begin
      int seen_nack = 0;
      bit first_out = 1'b1;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            // R1
            check(in_ready && !tx_req, "R1 reset state", {in_ready, tx_req}, 2);
         end else begin
            if (first_out) begin
               first_out = 1'b0;
               check(in_ready && !tx_req, "R1 first cycle out of reset", {in_ready, tx_req}, 2);
            end
            // R3 R6: ready follows the held count; a counted stale answer would skew it
            check(in_ready == ((accepted - acked) < D), "R3 R6 ready vs held count",
                  in_ready, (accepted - acked) < D);
            if (!in_ready) full_seen++;
            // R8
            if (phase == 1) check(in_ready, "R8 stream stalled without negatives", in_ready, 1);
            if (nack_events != seen_nack) begin
               seen_nack = nack_events;
               // R5
               check(tx_req && held_q.size() > 0 && tx_flit == held_q[0], "R5 replay head",
                     longint'(tx_flit), (held_q.size() > 0) ? longint'(held_q[0]) : -1);
            end
         end
      end
   end

   task automatic offer(input logic [W-1:0] d, input int gap_pct);
      do begin
         @(negedge clk);
         in_valid = (int'($urandom_range(0, 99)) >= gap_pct);
         in_flit  = d;
         @(posedge clk);
      end while (!(in_valid && in_ready));
      accepted++;
      exp_q.push_back(d);
      held_q.push_back(d);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // phase 1: clean stream (R2 R8)
      phase = 1; nack_pct = 0;
      for (int i = 0; i < 60; i++) offer(W'($urandom), 0);
      // phase 2: gappy input, moderate negatives (R5 R6 R9)
      phase = 2; nack_pct = 25;
      for (int i = 0; i < 150; i++) offer(W'($urandom), 30);
      // phase 3: full pressure, frequent negatives fill the store (R3)
      phase = 3; nack_pct = 60;
      for (int i = 0; i < 120; i++) offer(W'($urandom), 0);
      @(negedge clk);
      in_valid = 1'b0;
      for (int i = 0; i < 5000 && !(delivered == accepted && acked == accepted); i++) @(posedge clk);
      @(negedge clk);
      check(exp_q.size() == 0, "R9 undelivered flits", exp_q.size(), 0);
      check(delivered == accepted, "R9 delivered count", delivered, accepted);
      check(acked == accepted, "R4 R7 release count", acked, accepted);
      check(!tx_req && in_ready, "R7 idle after drain", {tx_req, in_ready}, 1);
      check(full_seen > 0, "R3 store filled under replay", full_seen, 1);
      check(nack_events > 0, "R5 negatives occurred", nack_events, 1);
      report();
   end

endmodule